// File: doc/BRIEF.md
# Line Idle and Break Timeout Detector

This block watches a single input line and measures how long that line has stayed in an "unwanted" state. It works like a retriggerable high-pass monostable. An internal counter advances once per system clock. A selectable gate condition clears the counter. If the counter climbs to a programmed threshold before any clear, the block reports a timeout. All of this runs in hardware, so no software has to reload a timer on every edge.

The gate condition picks what the block detects:

- Clearing while the line is high detects a long low, such as a UART break.
- Clearing while the line is low detects a long high, such as a pause between packets.
- Clearing on any edge detects a line that has stopped toggling at either level, which makes the block a watchdog for activity.

The line passes through a two-flop synchronizer before any use. A timeout sets a sticky flag and produces a one-cycle event pulse. The flag stays set until a clear strobe arrives or the configuration changes.

Top module: `line_idle_watch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `timeout_flag_o` and `timeout_pulse_o` are 0.
- R2: With `gate_sel_i` = 2'b00, the counter is held at zero while the synchronized line is low, so a line held high long enough causes a timeout.
- R3: With `gate_sel_i` = 2'b01, the counter is held at zero while the synchronized line is high, so a line held low (a break) long enough causes a timeout.
- R4: With `gate_sel_i` = 2'b10 or 2'b11, the counter is cleared on any change of the synchronized line. A line that toggles more often than the threshold never times out. A line that stays at either level times out.
- R5: In the low-clear mode, suppose the line was low and is driven high just before clock edge k, and the threshold is L. Then `timeout_pulse_o` is high for exactly the one cycle that follows edge k+1+L.
- R6: A timeout sets `timeout_flag_o` in the same cycle as the pulse. The flag then stays set until it is cleared.
- R7: The counter saturates at the threshold. `timeout_pulse_o` fires only once per timeout, and it does not fire again until the gate condition has cleared the counter at least once.
- R8: Any change of `gate_sel_i` or `limit_i` clears both the counter and the flag on the next edge.
- R9: Holding `flag_clr_i` high for a cycle clears `timeout_flag_o` on the next edge. If a new timeout happens in that same cycle, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Monitored line, asynchronous to clk |
| gate_sel_i | input | 2 | Clear condition: 00 line low, 01 line high, 1x any edge |
| limit_i | input | CNT_W (16) | Timeout threshold in clock cycles |
| flag_clr_i | input | 1 | Clears the sticky flag |
| timeout_flag_o | output | 1 | Sticky timeout indication |
| timeout_pulse_o | output | 1 | One-cycle pulse per timeout |

## Verification
The line is driven three ways:

- Random holds: levels held for random lengths around the threshold, in every gate mode. These separate a hold that just reaches the limit from one that falls one cycle short.
- Steady toggling: this shows the edge mode keeps a busy line quiet, while a level mode still fires on the same waveform.
- Long holds: these show the counter saturates and the pulse does not repeat.

Directed cases measure the exact latency from a line transition to the pulse. They also place flag clears and configuration writes while a timeout is pending, to show that each clears the flag and that a timeout wins a coincident clear.

// File: rtl/idle_watch_pkg.sv
package idle_watch_pkg;
    typedef enum logic [1:0] {
        GATE_WHILE_LOW  = 2'b00,
        GATE_WHILE_HIGH = 2'b01,
        GATE_ON_EDGE    = 2'b10,
        GATE_ON_EDGE2   = 2'b11
    } gate_mode_e;
endpackage

// File: rtl/iw_sync.sv
module iw_sync #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/iw_gate.sv
module iw_gate
    import idle_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_s_i,
    input  logic [1:0] gate_sel_i,
    output logic       clr_o
);
    logic prev_d, prev_q;
    logic toggled;

    always_comb begin
        prev_d  = line_s_i;
        toggled = line_s_i ^ prev_q;
        case (gate_mode_e'(gate_sel_i))
            GATE_WHILE_LOW:  clr_o = ~line_s_i;
            GATE_WHILE_HIGH: clr_o = line_s_i;
            default:         clr_o = toggled;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    // R4
    edge_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_sel_i[1] && clr_o) |-> (line_s_i != $past(line_s_i)));
endmodule

// File: rtl/iw_counter.sv
module iw_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [1:0]       gate_sel_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             flag_clr_i,
    output logic             flag_o,
    output logic             pulse_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             flag;
        logic             pulse;
        logic [1:0]       sel_cfg;
        logic [CNT_W-1:0] lim_cfg;
    } state_t;

    state_t st_d, st_q;
    logic   cfg_chg;

    always_comb begin
        st_d         = st_q;
        st_d.pulse   = 1'b0;
        st_d.sel_cfg = gate_sel_i;
        st_d.lim_cfg = limit_i;
        cfg_chg      = (gate_sel_i != st_q.sel_cfg) || (limit_i != st_q.lim_cfg);
        if (cfg_chg) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
            st_d.flag  = 1'b0;
        end else begin
            if (flag_clr_i) st_d.flag = 1'b0;
            if (clr_i) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
            end else begin
                if (st_q.cnt < limit_i) st_d.cnt = st_q.cnt + 1'b1;
                if (st_d.cnt == limit_i && st_q.armed) begin
                    st_d.pulse = 1'b1;
                    st_d.armed = 1'b0;
                    st_d.flag  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign pulse_o = st_q.pulse;

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim_cfg);
    // R7
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);
    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> st_q.pulse);
    // R8
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!st_q.flag && st_q.cnt == '0));
    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cfg_chg) |=> st_q.cnt == '0);
endmodule

// File: rtl/line_idle_watch.sv
module line_idle_watch #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [1:0]       gate_sel_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             flag_clr_i,
    output logic             timeout_flag_o,
    output logic             timeout_pulse_o
);
    logic line_s;
    logic gate_clr;

    iw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (line_s)
    );

    iw_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_s_i   (line_s),
        .gate_sel_i (gate_sel_i),
        .clr_o      (gate_clr)
    );

    iw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (gate_clr),
        .gate_sel_i (gate_sel_i),
        .limit_i    (limit_i),
        .flag_clr_i (flag_clr_i),
        .flag_o     (timeout_flag_o),
        .pulse_o    (timeout_pulse_o)
    );

    // R6
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse_o |-> timeout_flag_o);
endmodule

// File: tb/line_idle_watch_test.sv
module line_idle_watch_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line = 1'b1;
    logic [1:0]    sel = 2'b00;
    logic [CW-1:0] lim = 16'd4;
    logic          fclr = 1'b0;
    logic          flag, pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pulses = 0;
    string tag = "R1";

    line_idle_watch #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .line_i(line), .gate_sel_i(sel),
        .limit_i(lim), .flag_clr_i(fclr),
        .timeout_flag_o(flag), .timeout_pulse_o(pulse)
    );

    always #4 clk = ~clk;

    // reference model built from the requirements
    logic m_s1, m_s2, m_p, m_arm, m_flag, m_pulse;
    logic [1:0]    m_sel;
    logic [CW-1:0] m_cnt, m_lim;

    function automatic logic gate_of(logic s, logic p, logic [1:0] g);
        if (g == 2'b00) return !s;
        if (g == 2'b01) return s;
        return s != p;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_p = 1; m_cnt = 0; m_arm = 1;
            m_flag = 0; m_pulse = 0; m_sel = 0; m_lim = 0;
        end else begin
            logic g;
            g = gate_of(m_s2, m_p, sel);
            m_pulse = 0;
            if (sel != m_sel || lim != m_lim) begin
                m_cnt = 0; m_arm = 1; m_flag = 0;
            end else begin
                if (fclr) m_flag = 0;
                if (g) begin
                    m_cnt = 0; m_arm = 1;
                end else begin
                    if (m_cnt < lim) m_cnt = m_cnt + 1;
                    if (m_cnt == lim && m_arm) begin
                        m_pulse = 1; m_arm = 0; m_flag = 1;
                    end
                end
            end
            m_sel = sel; m_lim = lim;
            m_p = m_s2; m_s2 = m_s1; m_s1 = line;
        end
    end

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (pulse) pulses++;
            chk(flag == m_flag, {tag, " flag (R6)"}, flag, m_flag);
            chk(pulse == m_pulse, {tag, " pulse (R7)"}, pulse, m_pulse);
        end
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1d1e));
        wait_n(3);
        chk(flag == 0 && pulse == 0, "R1 reset outputs", flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flag == 0 && pulse == 0, "R1 after reset", flag, 0);

        // R5 exact latency, low-clear mode
        tag = "R5"; sel = 2'b00; lim = 6; line = 0;
        wait_n(12);
        begin
            int n;
            n = 0;
            line = 1;
            do begin @(negedge clk); n++; end while (!pulse && n < 40);
            chk(n == 8, "R5 latency", n, 8);
        end

        // R3 break in high-clear mode, R7 single pulse on long hold
        tag = "R3"; line = 1; sel = 2'b01; lim = 10;
        wait_n(5);
        pulses = 0; line = 0;
        wait_n(60);
        chk(pulses == 1, "R7 one pulse on long hold", pulses, 1);
        chk(flag == 1, "R3 break flagged", flag, 1);

        // R9 clear strobe
        tag = "R9"; fclr = 1; @(negedge clk); fclr = 0; @(negedge clk);
        chk(flag == 0, "R9 flag cleared", flag, 0);

        // R9 coincident clear and timeout: set wins
        line = 1; wait_n(4); line = 0;
        wait_n(11);
        fclr = 1; @(negedge clk); fclr = 0;
        wait_n(3);
        chk(flag == 1, "R9 set wins over clear", flag, 1);

        // R8 configuration write clears flag
        tag = "R8"; lim = 11; wait_n(2);
        chk(flag == 0, "R8 cfg clears flag", flag, 0);

        // R4 toggling in edge mode never times out
        tag = "R4"; sel = 2'b10; lim = 8; pulses = 0;
        for (int i = 0; i < 20; i++) begin line = ~line; wait_n(5); end
        chk(pulses == 0, "R4 busy line quiet", pulses, 0);
        pulses = 0; wait_n(40);
        chk(pulses == 1, "R4 stalled line fires", pulses, 1);

        // R2 pause in low-clear mode
        tag = "R2"; sel = 2'b00; line = 0; wait_n(5); pulses = 0;
        line = 1; wait_n(30);
        chk(pulses == 1 && flag == 1, "R2 pause flagged", pulses, 1);

        // random phases across all modes
        for (int ph = 0; ph < 300; ph++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) begin
                sel = 2'($urandom_range(0, 3));
                lim = CW'($urandom_range(1, 20));
            end
            case (sel)
                2'b00: tag = "R2";
                2'b01: tag = "R3";
                default: tag = "R4";
            endcase
            line = 1'($urandom_range(0, 1));
            fclr = ($urandom_range(0, 7) == 0);
            @(negedge clk); fclr = 0;
            wait_n($urandom_range(0, int'(lim) + 6));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule